// File: doc/BRIEF.md
# Byte-Lane Static RAM Sequencer

This block sits between a clocked request port and a 32-bit asynchronous static RAM of 256K words. The array is split into four byte-wide lanes, each with its own active-low select. A single request carries a word address, write data, a byte mask and a direction flag. The sequencer runs the select, write strobe, output enable, address and data-bus enable through a fixed series of states. Every timing minimum of the memory is turned into a whole number of clock cycles, rounded up from nanosecond parameters.

Writes keep output enable high for the whole access. The strobe is always held low for the stretched length, which is the larger of the minimum pulse width and the sum of the strobe-to-float time and the data setup time. The bus is driven only while the strobe is low, and the lane selects rise one cycle after the bus is released. Reads select all four lanes, wait out the access time and return the whole word with a one-cycle valid pulse.

After each reset the four module-depth sense pins are sampled once. A flag is raised if they do not show the 256K-deep pattern.

Top module: `sram_lane_ctrl`

## Requirements
- R1: One cycle after reset is released, `req_ready` is 1 and the memory pins are idle: every lane select high, write strobe high, output enable high, data bus not driven, `rd_valid` 0.
- R2: During a write, lane select `mem_cs_n[i]` is low exactly when `req_be[i]` is 1. Lane i is data bits 8i+7..8i. Lanes whose enable bit is 0 keep their stored byte, and a write with a zero mask changes nothing.
- R3: A read drives all four lane selects low, output enable low and write strobe high. It returns the full stored word on `rd_data`, with `rd_valid` high for exactly one cycle.
- R4: During a write, output enable stays high. The write strobe stays low for at least max(ceil(T_WP/Tclk), ceil((T_WHZ+T_DW)/Tclk)) cycles, which is 2 at the default parameters.
- R5: The data bus is driven only while the write strobe is low and output enable is high. The lane selects do not change in the cycle right after the bus was driven.
- R6: `mem_addr` changes only when the write strobe was high and all lane selects were high in the previous cycle.
- R7: Read data is captured only after the configured access time has elapsed since the selects fell with a stable address.
- R8: After the write strobe rises, the address is held for at least ceil(T_WR/Tclk) cycles (minimum 1).
- R9: After each reset, `id_err` is 0 only if `mem_id` reads 4'b1100: bits 0 and 1 low, bits 2 and 3 high.
- R10: While an access is in progress, `req_ready` is 0. A request presented then and withdrawn before `req_ready` returns has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte mask, bit i for lane i |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 32 | Read word |
| id_err | output | 1 | Depth sense pins do not show 256K |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 4 | Active-low lane selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 32 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable of the data bus driver |
| mem_dq_in | input | 32 | Data returned from memory |
| mem_id | input | 4 | Depth sense pins |

## Verification
Full-word writes followed by reads show that the whole word path and the read access wait work. The modelled array returns junk until the access time is met, so a short wait shows up as a data mismatch. Masked writes with the patterns 0101, 1000 and 0000 over a known word separate correct lane selection from lane swaps or stray selects. Back-to-back mixed accesses at walking addresses check the address-change and bus-release rules between accesses, and a request withdrawn while the block is busy must leave its address untouched. Three resets with the sense pins at 1100, 1101 and 0100 separate the one good pattern from single-bit faults in either half.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int ID_W = 4;
    localparam logic [ID_W-1:0] ID_DEPTH_256K = 4'b1100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_DONE
    } seq_state_e;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
    parameter int LANES = 4
) (
    input  logic             is_write,
    input  logic [LANES-1:0] byte_en,
    output logic [LANES-1:0] sel_n
);
    // writes select only the masked lanes, reads select every lane
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign sel_n[i] = is_write ? ~byte_en[i] : 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sram_id_check.sv
module sram_id_check
    import sram_lane_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id_pins,
    output logic            id_done,
    output logic            id_err
);
    typedef struct packed {
        logic done;
        logic err;
    } id_regs_t;

    id_regs_t id_d, id_q;

    always_comb begin
        id_d = id_q;
        if (!id_q.done) begin
            id_d.done = 1'b1;
            id_d.err  = (id_pins != ID_DEPTH_256K);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= '0;
        else        id_q <= id_d;
    end

    assign id_done = id_q.done;
    assign id_err  = id_q.err;
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 32,
    parameter int LANES   = 4,
    parameter int ACC_CYC = 2,
    parameter int STB_CYC = 2,
    parameter int REC_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_ok,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  lane_sel_n,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_CYC = max2(max2(ACC_CYC, STB_CYC), REC_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              rvld;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.rvld = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (go_ok && req_valid) begin
                    seq_d.st    = ST_SETUP;
                    seq_d.wr    = req_write;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.cs_n  = lane_sel_n;
                    seq_d.oe_n  = req_write;
                end
            end
            ST_SETUP: begin
                seq_d.st = ST_STROBE;
                if (seq_q.wr) begin
                    seq_d.cnt   = CNT_W'(STB_CYC - 1);
                    seq_d.we_n  = 1'b0;
                    seq_d.dq_oe = 1'b1;
                end else begin
                    seq_d.cnt = CNT_W'(ACC_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (seq_q.wr) begin
                    seq_d.st    = ST_RECOVER;
                    seq_d.we_n  = 1'b1;
                    seq_d.dq_oe = 1'b0;
                    seq_d.cnt   = CNT_W'(REC_CYC - 1);
                end else begin
                    seq_d.st    = ST_DONE;
                    seq_d.rdata = mem_dq_in;
                    seq_d.rvld  = 1'b1;
                    seq_d.cs_n  = '1;
                    seq_d.oe_n  = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.st   = ST_DONE;
                    seq_d.cs_n = '1;
                end
            end
            ST_DONE: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.st    <= ST_IDLE;
            seq_q.cs_n  <= '1;
            seq_q.we_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready  = (seq_q.st == ST_IDLE) && go_ok;
    assign rd_valid   = seq_q.rvld;
    assign rd_data    = seq_q.rdata;
    assign mem_addr   = seq_q.addr;
    assign mem_cs_n   = seq_q.cs_n;
    assign mem_we_n   = seq_q.we_n;
    assign mem_oe_n   = seq_q.oe_n;
    assign mem_dq_out = seq_q.wdata;
    assign mem_dq_oe  = seq_q.dq_oe;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int LANE_W    = 8,
    parameter int LANES     = 4,
    parameter int CLK_NS    = 20,
    parameter int T_ACC_NS  = 25,
    parameter int T_WP_NS   = 15,
    parameter int T_WHZ_NS  = 10,
    parameter int T_DW_NS   = 15,
    parameter int T_WR_NS   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LANES*LANE_W-1:0]  req_wdata,
    input  logic [LANES-1:0]         req_be,
    output logic                     req_ready,
    output logic                     rd_valid,
    output logic [LANES*LANE_W-1:0]  rd_data,
    output logic                     id_err,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [LANES-1:0]         mem_cs_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [LANES*LANE_W-1:0]  mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [LANES*LANE_W-1:0]  mem_dq_in,
    input  logic [ID_W-1:0]          mem_id
);
    localparam int DATA_W  = LANES * LANE_W;
    localparam int ACC_CYC = max2(ns_to_cyc(T_ACC_NS, CLK_NS), 1);
    localparam int STB_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS),
                                       ns_to_cyc(T_WHZ_NS + T_DW_NS, CLK_NS)), 1);
    localparam int REC_CYC = max2(ns_to_cyc(T_WR_NS, CLK_NS), 1);

    logic             id_done;
    logic [LANES-1:0] lane_sel_n;

    sram_id_check u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .id_pins (mem_id),
        .id_done (id_done),
        .id_err  (id_err)
    );

    sram_lane_map #(.LANES(LANES)) u_map (
        .is_write (req_write),
        .byte_en  (req_be),
        .sel_n    (lane_sel_n)
    );

    sram_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LANES   (LANES),
        .ACC_CYC (ACC_CYC),
        .STB_CYC (STB_CYC),
        .REC_CYC (REC_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_ok      (id_done),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .lane_sel_n (lane_sel_n),
        .req_ready  (req_ready),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W  = 18,
    parameter int LANES   = 4,
    parameter int STB_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic [7:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          we_low_cnt <= '0;
        else if (!mem_we_n)  we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1;
        else                 we_low_cnt <= '0;
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_read_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_cs_n == '0 && mem_we_n));

    assert_rvld_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_oe_high_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_strobe_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_low_cnt) >= STB_CYC));

    assert_bus_only_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    assert_cs_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |=> $stable(mem_cs_n));

    assert_addr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> ($past(mem_we_n) && (&$past(mem_cs_n))));

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != '1) |-> !req_ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .LANES   (LANES),
    .STB_CYC (STB_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;
    localparam int CLK_NS   = 20;
    localparam int T_ACC    = 25;
    localparam int WP_NEED  = 2;   // max(ceil(15/20), ceil((10+15)/20))
    localparam int REC_NEED = 1;   // ceil(1/20)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, rd_valid, id_err;
    logic [31:0] rd_data;
    logic [17:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_we_n, mem_oe_n, mem_dq_oe;
    logic [31:0] mem_dq_out;
    logic [31:0] mem_dq_in = 32'hBAD0_BAD0;
    logic [3:0]  mem_id = 4'b1100;

    always #10 clk = ~clk;

    sram_lane_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data), .id_err(id_err),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_id(mem_id)
    );

    // per-process counters
    int t_tot = 0, t_bad = 0, m_tot = 0, m_bad = 0, s_tot = 0, s_bad = 0, w_bad = 0;
    bit finished = 1'b0;

    logic [31:0] arr    [int];   // contents of the modelled array
    logic [31:0] shadow [int];   // expected contents from requests
    logic [31:0] exp_q  [$];

    function automatic logic [31:0] rd_arr(input int k);
        return arr.exists(k) ? arr[k] : 32'h0;
    endfunction
    function automatic logic [31:0] rd_sh(input int k);
        return shadow.exists(k) ? shadow[k] : 32'h0;
    endfunction

    task automatic chk_t(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        t_tot++;
        if (!ok) begin t_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
    endtask
    task automatic chk_m(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        m_tot++;
        if (!ok) begin m_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
    endtask

    // asynchronous array model with timing rule checks
    logic [17:0] p_addr = '0;
    logic [3:0]  p_cs_n = 4'hF;
    logic        p_we_n = 1'b1, p_dq_oe = 1'b0, p_sel = 1'b0;
    int          wl_cnt = 0, since_rise = 100, acc = 0;
    logic [31:0] lat_dq = '0;
    logic [3:0]  lat_cs = 4'hF;
    logic [17:0] lat_addr = '0;

    always @(posedge clk) begin
        logic sel;
        logic [31:0] w;
        if (rst_n) begin
            sel = !mem_oe_n && (mem_cs_n == 4'h0) && mem_we_n;
            if (mem_addr != p_addr) begin
                if (!p_we_n && p_cs_n != 4'hF)
                    chk_m(0, "R6 addr moved under write", {14'h0, mem_addr}, {14'h0, p_addr});
                if (since_rise < REC_NEED)
                    chk_m(0, "R8 recovery", since_rise, REC_NEED);
            end
            if (mem_dq_oe && !mem_oe_n) chk_m(0, "R5 bus contention", 1, 0);
            if (mem_dq_oe && mem_we_n)  chk_m(0, "R5 bus driven with strobe high", 1, 0);
            if (p_dq_oe && ((~p_cs_n) & mem_cs_n) != 4'h0)
                chk_m(0, "R5 select rose right after release", {28'h0, mem_cs_n}, {28'h0, p_cs_n});
            if (!mem_we_n) begin
                if (!mem_oe_n) chk_m(0, "R4 oe low during write", 0, 1);
                wl_cnt++;
                lat_dq = mem_dq_out; lat_cs = mem_cs_n; lat_addr = mem_addr;
            end
            if (mem_we_n && !p_we_n) begin
                chk_m(wl_cnt >= WP_NEED, "R4 strobe width", wl_cnt, WP_NEED);
                w = rd_arr(int'(lat_addr));
                for (int i = 0; i < 4; i++)
                    if (!lat_cs[i]) w[8*i +: 8] = lat_dq[8*i +: 8];
                arr[int'(lat_addr)] = w;
                wl_cnt = 0;
                since_rise = 0;
            end else if (since_rise < 100) since_rise++;
            if (sel && p_sel && mem_addr == p_addr) acc++;
            else if (sel) acc = 1;
            else acc = 0;
            mem_dq_in <= (sel && (acc + 1) * CLK_NS >= T_ACC) ? rd_arr(int'(mem_addr)) : 32'hBAD0_BAD0;
            p_addr = mem_addr; p_cs_n = mem_cs_n; p_we_n = mem_we_n;
            p_dq_oe = mem_dq_oe; p_sel = sel;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        logic [31:0] e;
        if (rst_n && rd_valid) begin
            s_tot++;
            if (exp_q.size() == 0) begin
                s_bad++; $display("FAIL R3 unexpected rd_valid act=%h exp=none", rd_data);
            end else begin
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    s_bad++; $display("FAIL R3/R7 read data act=%h exp=%h", rd_data, e);
                end
            end
        end
    end

    task automatic do_reset(input logic [3:0] id);
        @(negedge clk);
        rst_n = 1'b0; mem_id = id;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic issue(input bit wr, input logic [17:0] a, input logic [31:0] d, input logic [3:0] be);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        if (wr) begin
            logic [31:0] s;
            s = rd_sh(int'(a));
            for (int i = 0; i < 4; i++) if (be[i]) s[8*i +: 8] = d[8*i +: 8];
            shadow[int'(a)] = s;
        end else begin
            exp_q.push_back(rd_sh(int'(a)));
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr_chk(input logic [17:0] a, input logic [31:0] d, input logic [3:0] be);
        issue(1, a, d, be);
        @(negedge clk); // strobe phase
        chk_t(mem_cs_n == ~be, "R2 lane selects", {28'h0, mem_cs_n}, {28'h0, ~be});
        chk_t(!mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_out == d, "R4 write pins",
              {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b011);
    endtask

    task automatic rd_chk(input logic [17:0] a);
        issue(0, a, 32'h0, 4'h0);
        chk_t(mem_cs_n == 4'h0 && !mem_oe_n && mem_we_n, "R3 read pins",
              {mem_cs_n, mem_oe_n, mem_we_n}, 6'b000001);
    endtask

    task automatic drain;
        int n;
        n = 0;
        while ((exp_q.size() != 0 || !req_ready) && n < 200) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", t_tot + m_tot + s_tot + 1, t_bad + m_bad + s_bad + w_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        w_bad++;
        $display("FAIL watchdog act=hung exp=finish");
        summary();
    end

    initial begin
        do_reset(4'b1100);
        chk_t(req_ready && mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
              "R1 idle after reset", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 8'b11111110);
        chk_t(id_err == 1'b0, "R9 good id", {31'h0, id_err}, 0);

        wr_chk(18'h00010, 32'h1122_3344, 4'hF);
        rd_chk(18'h00010);
        wr_chk(18'h00010, 32'hAABB_CCDD, 4'b0101);
        rd_chk(18'h00010);                          // expect 11BB33DD
        wr_chk(18'h3FFFF, 32'hCAFE_F00D, 4'hF);
        wr_chk(18'h3FFFF, 32'h5500_0000, 4'b1000);
        rd_chk(18'h3FFFF);
        wr_chk(18'h3FFFF, 32'hFFFF_FFFF, 4'b0000);  // R2 zero mask
        rd_chk(18'h3FFFF);
        drain();
        chk_t(rd_sh(32'h3FFFF) == 32'h55FE_F00D, "R2 shadow sanity", rd_sh(32'h3FFFF), 32'h55FE_F00D);

        for (int k = 0; k < 18; k++) begin
            issue(1, 18'(1 << k), 32'h0101_0101 * (k + 1), 4'hF);
            issue(0, 18'(1 << k), 32'h0, 4'h0);
        end
        for (int k = 0; k < 8; k++) issue(1, 18'(k), 32'hA5A5_0000 | k, 4'(k[3:0] | 4'h1));
        for (int k = 0; k < 8; k++) issue(0, 18'(k), 32'h0, 4'h0);
        drain();

        // R10: request withdrawn while busy
        issue(1, 18'h00100, 32'h0BAD_F00D, 4'hF);
        issue(1, 18'h00200, 32'h1234_5678, 4'hF);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00100; req_wdata = 32'hDEAD_DEAD; req_be = 4'hF;
        for (int i = 0; i < 2; i++) begin
            chk_t(req_ready == 1'b0, "R10 busy", {31'h0, req_ready}, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        rd_chk(18'h00100);
        drain();

        do_reset(4'b1101);
        chk_t(id_err == 1'b1, "R9 bit0 open", {31'h0, id_err}, 1);
        do_reset(4'b0100);
        chk_t(id_err == 1'b1, "R9 bit3 low", {31'h0, id_err}, 1);
        do_reset(4'b1100);
        chk_t(id_err == 1'b0, "R9 good again", {31'h0, id_err}, 0);
        rd_chk(18'h00010);
        drain();
        chk_t(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
        summary();
    end
endmodule